// File: doc/BRIEF.md
# Serial Channel Mode Byte Router

This block sits between a host data port, a serial line receiver and a serial transmitter. It holds one byte FIFO for the receive direction and one for the transmit direction. A 2-bit channel mode input decides where each byte goes. A byte arriving from the line can go to the receive FIFO, to the transmit FIFO, or to both. A byte written by the host can go to the transmit FIFO or to the receive FIFO, or it can be dropped. Serialisation and baud timing are handled outside this block. The transmitter pulls bytes through a valid/ready pair.

A 9-bit control register sits inside the block. Its low six bits control the two directions. Each direction has a gate, a clear bit and a disable bit, and a disable beats an enable. Each direction also has a small controller with three states:

- `PS_OFF`: the path is inactive.
- `PS_LIVE`: the path accepts bytes.
- `PS_FLUSH`: a one-cycle state that empties the FIFO of that direction.

The controller has these transitions:

- `go_live` (`PS_OFF`→`PS_LIVE`): taken when the enable bit is set and the disable bit is clear.
- `go_off` (`PS_LIVE`→`PS_OFF`): taken when that gate condition is lost.
- `start_flush` (`PS_OFF` or `PS_LIVE`→`PS_FLUSH`): taken when the clear bit is set.
- `end_flush` (`PS_FLUSH`→`PS_LIVE` or `PS_OFF`): always taken after one cycle. It goes to the state the gate condition selects. The clear bit drops when this transition is taken.

Both FIFOs have a fixed depth. Overflow is reported by a one-cycle pulse per direction.

Top module: `uart_mode_router`

## Requirements
- R1: The `mode` value selects where a line byte goes: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. A line byte (`rx_valid`) is pushed into the receive FIFO in modes 0 and 1, and into the transmit FIFO in modes 1 and 3.
- R2: A host write (`host_wr`) is pushed into the transmit FIFO in mode 0 and into the receive FIFO in mode 2. In modes 1 and 3 it is dropped and neither count changes.
- R3: The receive path is live only while control bit 2 is 1 and control bit 3 is 0. A change takes effect one cycle after the control register updates. While the receive path is not live, pushes into the receive FIFO are dropped and host reads do not pop it.
- R4: The transmit path uses control bit 4 as its enable and control bit 5 as its disable, with the same rule. While it is not live, pushes into the transmit FIFO are dropped.
- R5: Writing control bit 0 as 1 empties the receive FIFO. Writing control bit 1 as 1 empties the transmit FIFO. In both cases the FIFO is empty and the bit reads back 0 two cycles after the control write.
- R6: A push into a full receive FIFO (64 entries) is discarded. The count stays at 64 and `rx_ovf` is high for exactly one cycle.
- R7: A push into a full transmit FIFO (64 entries) is discarded. The count stays at 64 and `tx_ovf` is high for exactly one cycle.
- R8: `rd_data` updates in the cycle after a `host_rd` strobe and returns the oldest receive byte. A read of an empty receive FIFO returns 0 and leaves the count unchanged. A read while the receive path is not live also returns 0 and leaves the count unchanged.
- R9: `tx_valid` is high whenever the transmit FIFO holds a byte, and `tx_data` is the oldest byte. Each cycle with `tx_valid` and `tx_ready` both high removes one byte, so bytes leave in arrival order.
- R10: After reset the control register reads 0x128, so both paths are disabled. Both counts are 0, both overflow pulses are low, `tx_valid` is low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Channel mode (0 normal, 1 echo, 2 local loopback, 3 remote loopback) |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write value |
| ctrl_q | output | 9 | Control register contents |
| host_wr | input | 1 | Host data write strobe |
| host_wdata | input | 8 | Host data write byte |
| host_rd | input | 1 | Host data read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| rx_valid | input | 1 | Received line byte strobe |
| rx_data | input | 8 | Received line byte |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_ovf | output | 1 | Receive overflow pulse |
| tx_ovf | output | 1 | Transmit overflow pulse |
| rx_count | output | 7 | Receive FIFO occupancy |
| tx_count | output | 7 | Transmit FIFO occupancy |

## Verification
The hardest situations to reach from the ports are the two overflow edges.

To reach them, the bench keeps the transmitter stalled and streams 64 line bytes, or 64 host writes. It then offers one more byte and checks that the count holds and that the overflow pulse lasts exactly one cycle.

A second hard case is a read refused by a gated path. To reach it, the bench leaves a byte in the receive FIFO and then sets the disable bit. It checks that the read returns 0 and the byte is still there once the path is enabled again.

Read data and transmitter output are compared in order against queues of expected bytes.

// File: rtl/uart_mode_router_pkg.sv
package uart_mode_router_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL    = 2'd0,
        CH_ECHO      = 2'd1,
        CH_LOCAL_LB  = 2'd2,
        CH_REMOTE_LB = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_LIVE  = 2'd1,
        PS_FLUSH = 2'd2
    } path_state_e;

    localparam int CTRL_W          = 9;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
    localparam int NUM_PATHS       = 2;   // 0: receive, 1: transmit

endpackage

// File: rtl/path_ctl.sv
module path_ctl
    import uart_mode_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    input  logic gate_off,
    input  logic clear_req,
    output logic live,
    output logic flushing
);

    path_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF: begin
                if (clear_req)                  state_d = PS_FLUSH;  // start_flush
                else if (gate_on && !gate_off)  state_d = PS_LIVE;   // go_live
            end
            PS_LIVE: begin
                if (clear_req)                  state_d = PS_FLUSH;  // start_flush
                else if (!gate_on || gate_off)  state_d = PS_OFF;    // go_off
            end
            PS_FLUSH: begin
                state_d = (gate_on && !gate_off) ? PS_LIVE : PS_OFF; // end_flush
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_comb begin
        live     = (state_q == PS_LIVE);
        flushing = (state_q == PS_FLUSH);
    end

    // R5
    flush_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_FLUSH) |=> (state_q != PS_FLUSH));

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             ovf
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [CW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign count   = wptr - rptr;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            ovf <= push && full;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr[AW-1:0]] <= din;
    end

    // R6
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
    // R8
    fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (count == '0));
    // R5
    fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !ovf));

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
    import uart_mode_router_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int DATA_W     = 8,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              rx_ovf,
    output logic              tx_ovf,
    output logic [CW-1:0]     rx_count,
    output logic [CW-1:0]     tx_count
);

    localparam int RXP = 0;
    localparam int TXP = 1;

    chan_mode_e              cmode;
    logic [NUM_PATHS-1:0]    live, flushing, push, pop, full, empty, ovf;
    logic [DATA_W-1:0]       din  [NUM_PATHS];
    logic [DATA_W-1:0]       dout [NUM_PATHS];
    logic [CW-1:0]           cnt  [NUM_PATHS];

    assign cmode = chan_mode_e'(mode);

    // control register: clear bits drop when their path leaves PS_FLUSH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end else begin
            for (int p = 0; p < NUM_PATHS; p++) begin
                if (flushing[p]) ctrl_q[p] <= 1'b0;
            end
        end
    end

    // byte steering by channel mode
    always_comb begin
        push[RXP] = live[RXP] &&
                    ((rx_valid && (cmode == CH_NORMAL || cmode == CH_ECHO)) ||
                     (host_wr  && (cmode == CH_LOCAL_LB)));
        din[RXP]  = (cmode == CH_LOCAL_LB) ? host_wdata : rx_data;
        push[TXP] = live[TXP] &&
                    ((host_wr  && (cmode == CH_NORMAL)) ||
                     (rx_valid && (cmode == CH_ECHO || cmode == CH_REMOTE_LB)));
        din[TXP]  = (cmode == CH_NORMAL) ? host_wdata : rx_data;
        pop[RXP]  = host_rd && live[RXP] && !empty[RXP];
        pop[TXP]  = tx_ready && !empty[TXP];
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        path_ctl u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .gate_on   (ctrl_q[2 + 2*p]),
            .gate_off  (ctrl_q[3 + 2*p]),
            .clear_req (ctrl_q[p]),
            .live      (live[p]),
            .flushing  (flushing[p])
        );

        byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (flushing[p]),
            .push  (push[p]),
            .pop   (pop[p]),
            .din   (din[p]),
            .dout  (dout[p]),
            .count (cnt[p]),
            .full  (full[p]),
            .empty (empty[p]),
            .ovf   (ovf[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (host_rd) rd_data <= pop[RXP] ? dout[RXP] : '0;
    end

    assign tx_valid = !empty[TXP];
    assign tx_data  = dout[TXP];
    assign rx_ovf   = ovf[RXP];
    assign tx_ovf   = ovf[TXP];
    assign rx_count = cnt[RXP];
    assign tx_count = cnt[TXP];

    // R2
    host_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (cmode == CH_ECHO || cmode == CH_REMOTE_LB) && !rx_valid &&
         !host_rd && !tx_ready && flushing == '0)
        |=> ($stable(rx_count) && $stable(tx_count)));
    // R3
    rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live[RXP] && !flushing[RXP]) |=> $stable(rx_count));
    // R8
    rd_gated_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !live[RXP]) |=> (rd_data == '0));
    // R7
    tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(FIFO_DEPTH)) && (rx_count <= CW'(FIFO_DEPTH)));

endmodule

// File: tb/uart_mode_router_tb_top.sv
module uart_mode_router_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       ctrl_we = 1'b0;
    logic [8:0] ctrl_wdata = '0;
    logic [8:0] ctrl_q;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       rx_ovf, tx_ovf;
    logic [6:0] rx_count, tx_count;

    int total = 0;
    int bad = 0;
    bit rd_seen = 1'b0;

    byte unsigned exp_rd[$];
    string        rd_tag[$];
    byte unsigned exp_tx[$];

    always #10 clk = ~clk;   // 50 MHz

    uart_mode_router dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .rd_data(rd_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_ovf(rx_ovf), .tx_ovf(tx_ovf),
        .rx_count(rx_count), .tx_count(tx_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ctrl(input logic [8:0] v, input int settle);
        ctrl_we = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_we = 1'b0;
        repeat (settle) tick();
    endtask

    task automatic line_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic host_byte(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] e, input string tag);
        exp_rd.push_back(e);
        rd_tag.push_back(tag);
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        tick();
    endtask

    task automatic drain(input int n);
        tx_ready = 1'b1;
        repeat (n) tick();
        tx_ready = 1'b0;
        check(tx_count == 0, "R9", "tx_count after drain", tx_count, 0);
        check(!tx_valid, "R9", "tx_valid after drain", tx_valid, 0);
    endtask

    // read-data monitor
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_rd.size() == 0) begin
                check(1'b0, "R8", "unexpected read", rd_data, 0);
            end else begin
                automatic byte unsigned e = exp_rd.pop_front();
                automatic string t = rd_tag.pop_front();
                check(rd_data == e, t, "rd_data", rd_data, e);
            end
        end
        rd_seen = host_rd;
    end

    // transmitter monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) begin
                check(1'b0, "R9", "unexpected tx byte", tx_data, 0);
            end else begin
                automatic byte unsigned e = exp_tx.pop_front();
                check(tx_data == e, "R9", "tx_data order", tx_data, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R10 reset state
        check(ctrl_q == 9'h128, "R10", "ctrl reset", ctrl_q, 9'h128);
        check(rx_count == 0 && tx_count == 0, "R10", "counts", rx_count + tx_count, 0);
        check(!tx_valid && !rx_ovf && !tx_ovf, "R10", "flags", {tx_valid, rx_ovf, tx_ovf}, 0);
        check(rd_data == 0, "R10", "rd_data", rd_data, 0);

        // R3/R4: paths start disabled, pushes dropped
        line_byte(8'h11);
        host_byte(8'h22);
        tick();
        check(rx_count == 0, "R3", "rx push while off", rx_count, 0);
        check(tx_count == 0, "R4", "tx push while off", tx_count, 0);

        // enable both (bit2, bit4), normal mode
        set_ctrl(9'h114, 2);
        mode = 2'd0;
        line_byte(8'hA1);
        line_byte(8'hA2);
        check(rx_count == 2 && tx_count == 0, "R1", "normal line routing",
              {rx_count, tx_count}, {7'd2, 7'd0});
        host_read(8'hA1, "R8");
        host_read(8'hA2, "R8");
        host_byte(8'hC1);
        host_byte(8'hC2);
        check(tx_count == 2 && rx_count == 0, "R2", "normal host routing",
              {rx_count, tx_count}, {7'd0, 7'd2});
        check(tx_valid && tx_data == 8'hC1, "R9", "tx head", tx_data, 8'hC1);
        exp_tx.push_back(8'hC1); exp_tx.push_back(8'hC2);
        drain(4);

        // echo mode
        mode = 2'd1;
        line_byte(8'hE5);
        check(rx_count == 1 && tx_count == 1, "R1", "echo line routing",
              {rx_count, tx_count}, {7'd1, 7'd1});
        host_byte(8'h99);
        check(rx_count == 1 && tx_count == 1, "R2", "echo host dropped",
              {rx_count, tx_count}, {7'd1, 7'd1});
        host_read(8'hE5, "R1");
        exp_tx.push_back(8'hE5);
        drain(3);

        // local loopback
        mode = 2'd2;
        host_byte(8'h5A);
        check(rx_count == 1 && tx_count == 0, "R2", "local host routing",
              {rx_count, tx_count}, {7'd1, 7'd0});
        line_byte(8'h77);
        check(rx_count == 1 && tx_count == 0, "R1", "local line ignored",
              {rx_count, tx_count}, {7'd1, 7'd0});
        host_read(8'h5A, "R2");

        // remote loopback
        mode = 2'd3;
        line_byte(8'h3C);
        check(rx_count == 0 && tx_count == 1, "R1", "remote line routing",
              {rx_count, tx_count}, {7'd0, 7'd1});
        host_byte(8'h44);
        check(tx_count == 1 && rx_count == 0, "R2", "remote host dropped",
              {rx_count, tx_count}, {7'd0, 7'd1});
        exp_tx.push_back(8'h3C);
        drain(3);

        // R8 empty read
        mode = 2'd0;
        host_read(8'h00, "R8");
        check(rx_count == 0, "R8", "empty read count", rx_count, 0);

        // R8/R3 read while receive path disabled
        line_byte(8'h6B);
        set_ctrl(9'h118, 2);
        host_read(8'h00, "R3");
        check(rx_count == 1, "R3", "gated read keeps byte", rx_count, 1);
        set_ctrl(9'h11C, 2);
        line_byte(8'h12);
        check(rx_count == 1, "R3", "disable beats enable", rx_count, 1);
        set_ctrl(9'h114, 2);
        host_read(8'h6B, "R3");

        // R4 transmit path gated by its disable bit
        set_ctrl(9'h134, 2);
        host_byte(8'h0F);
        check(tx_count == 0, "R4", "tx disable drops", tx_count, 0);
        set_ctrl(9'h114, 2);

        // R5 receive clear
        line_byte(8'h01);
        line_byte(8'h02);
        set_ctrl(9'h115, 2);
        check(rx_count == 0, "R5", "rx cleared", rx_count, 0);
        check(ctrl_q[0] == 1'b0, "R5", "rx clear bit drops", ctrl_q[0], 0);
        line_byte(8'h03);
        check(rx_count == 1, "R5", "rx live after clear", rx_count, 1);
        host_read(8'h03, "R5");

        // R5 transmit clear
        host_byte(8'h04);
        host_byte(8'h05);
        set_ctrl(9'h116, 2);
        check(tx_count == 0, "R5", "tx cleared", tx_count, 0);
        check(ctrl_q[1] == 1'b0, "R5", "tx clear bit drops", ctrl_q[1], 0);

        // R6 receive overflow
        for (int i = 0; i < 64; i++) line_byte(8'(i + 16));
        check(rx_count == 64 && !rx_ovf, "R6", "rx full no ovf", rx_count, 64);
        line_byte(8'hFF);
        check(rx_ovf == 1'b1, "R6", "rx_ovf pulse", rx_ovf, 1);
        check(rx_count == 64, "R6", "rx count held", rx_count, 64);
        tick();
        check(rx_ovf == 1'b0, "R6", "rx_ovf one cycle", rx_ovf, 0);
        host_read(8'd16, "R6");
        set_ctrl(9'h115, 2);

        // R7 transmit overflow
        for (int i = 0; i < 64; i++) begin
            host_byte(8'(i + 100));
            exp_tx.push_back(8'(i + 100));
        end
        host_byte(8'hEE);
        check(tx_ovf == 1'b1, "R7", "tx_ovf pulse", tx_ovf, 1);
        check(tx_count == 64, "R7", "tx count held", tx_count, 64);
        tick();
        check(tx_ovf == 1'b0, "R7", "tx_ovf one cycle", tx_ovf, 0);
        drain(66);

        tick();
        check(exp_rd.size() == 0, "R8", "reads outstanding", exp_rd.size(), 0);
        check(exp_tx.size() == 0, "R9", "tx bytes outstanding", exp_tx.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule